// File: doc/BRIEF.md
# Vertically Encoded Microprogrammed Control Unit

This block is the control section of a small processor. It keeps its control store as fixed logic of 31-bit microinstructions. Each microinstruction packs every group of mutually exclusive datapath strobes into a short code field. A sequencer steps a microaddress register through the store. Per-field decoders expand each code into a one-hot strobe vector, and every field has a code that asserts nothing.

The store holds two routines. A shared instruction-fetch routine starts at address 100. On its last step it waits for memory and then jumps through an opcode lookup. The add routine at addresses 200 to 202 reads two registers, adds them and writes the result back. It then raises End and branches unconditionally back to fetch. When a step would need two strobes from the same group, the microcode spreads them over separate microinstructions. For this reason the memory read request sits one step after the address strobe.

The microinstruction fields, from most to least significant, are: source select 2, branch condition 3, End 1, out-gate 3, in-gate 3, misc 3, register select 2, ALU 4 and branch target 10. The source-select codes are 00 next address, 01 opcode lookup, 10 fetch entry and 11 branch target. The branch-condition codes are 000 always, 001 CON set, 010 CON clear, 011 count zero, 100 count nonzero and 101 never. The condition inputs are wired into this branch logic, but neither routine tests them.

Top module: `vmc_control_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the unit presents the step at fetch entry 100. That step drives out_strb bit 0 (PC out), in_strb bit 0 (MA in), misc_strb bit 5 (C in) and alu_strb bit 3 (increment by 4). No register select is driven and `end_o` is low.
- R2: Each strobe vector is one-hot or zero, and the bit index equals the field code. The none codes are out 7, in 6 and 7, misc 7, register 3 and ALU 14, and none of them drives a strobe.
- R3: Fetch runs 100, 101, 102 on successive cycles. Step 101 drives out bit 1 (C out), in bit 1 (PC in) and misc bit 0 (Read). Step 102 drives out bit 2 (MD out), in bit 2 (IR in) and misc bit 1 (Wait).
- R4: While step 102 is presented and `mem_done` is low, the microaddress holds and step 102 repeats on every cycle.
- R5: On the cycle after step 102 with `mem_done` high, the unit moves to 200 when `opcode` equals ADD_OPCODE (default 12). For any other opcode it moves to 100.
- R6: Step 200 drives out bit 3 (R out), in bit 3 (A in) and register bit 1 (rb). Step 201 drives out bit 3, register bit 2 (rc), alu bit 0 (ADD) and misc bit 5 (C in), with no in strobe.
- R7: Step 202 drives out bit 1, in bit 4 (R in), register bit 0 (ra) and `end_o`. The next cycle presents step 100.
- R8: A reset that is asserted in the middle of a routine returns the unit to step 100 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_done | input | 1 | Memory transfer finished |
| opcode | input | 5 | Opcode of the current instruction |
| cond_con | input | 1 | Branch condition flag from the datapath |
| cond_zero | input | 1 | Shift count is zero |
| out_strb | output | 8 | One-hot bus-out gates |
| in_strb | output | 8 | One-hot bus-in gates |
| misc_strb | output | 8 | One-hot miscellaneous controls |
| rsel_strb | output | 4 | One-hot register field selects |
| alu_strb | output | 16 | One-hot ALU function selects |
| end_o | output | 1 | Last step of an instruction |

## Verification
The assertions check four behaviours on every cycle. Each strobe group stays one-hot or zero. A Wait step with memory not done holds the microaddress. A step with branch-never advances the address by one. A step with End set is followed by fetch entry 100. Whether each step drives the correct strobes can be shown only by the bench's scenarios. This covers the fetch and add sequences, the routing of a non-add opcode back to fetch, a long memory stall and a reset in the middle of a routine.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
    localparam int UADDR_W = 10;
    localparam int GATE_W  = 3;
    localparam int RSEL_W  = 2;
    localparam int ALU_W   = 4;
    localparam int SRC_W   = 2;
    localparam int COND_W  = 3;

    typedef struct packed {
        logic [SRC_W-1:0]   src;
        logic [COND_W-1:0]  cond;
        logic               fin;
        logic [GATE_W-1:0]  outg;
        logic [GATE_W-1:0]  ing;
        logic [GATE_W-1:0]  misc;
        logic [RSEL_W-1:0]  rsel;
        logic [ALU_W-1:0]   alu;
        logic [UADDR_W-1:0] target;
    } uword_t;

    localparam logic [SRC_W-1:0] SRC_NEXT    = 2'b00;
    localparam logic [SRC_W-1:0] SRC_LOOKUP  = 2'b01;
    localparam logic [SRC_W-1:0] SRC_FETCH   = 2'b10;
    localparam logic [SRC_W-1:0] SRC_TARGET  = 2'b11;

    localparam logic [COND_W-1:0] C_ALWAYS   = 3'b000;
    localparam logic [COND_W-1:0] C_CON      = 3'b001;
    localparam logic [COND_W-1:0] C_NOTCON   = 3'b010;
    localparam logic [COND_W-1:0] C_ZERO     = 3'b011;
    localparam logic [COND_W-1:0] C_NONZERO  = 3'b100;
    localparam logic [COND_W-1:0] C_NEVER    = 3'b101;

    localparam int OUT_NONE  = 7;
    localparam int IN_NONE   = 6;
    localparam int MISC_NONE = 7;
    localparam int RSEL_NONE = 3;
    localparam int ALU_NONE  = 14;
    localparam logic [GATE_W-1:0] MISC_WAIT = 3'b001;
endpackage

// File: rtl/vmc_onehot.sv
module vmc_onehot #(
    parameter int W    = 3,
    parameter int NONE = 7,
    parameter int MAXC = (1 << W) - 1
) (
    input  logic [W-1:0]        code,
    output logic [(1 << W)-1:0] strb
);
    localparam int N = 1 << W;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == NONE || i > MAXC) begin : g_off
            assign strb[i] = 1'b0;
        end else begin : g_on
            assign strb[i] = (code == W'(i));
        end
    end
endmodule

// File: rtl/vmc_store.sv
module vmc_store
    import vmc_pkg::*;
#(
    parameter int FETCH_BASE = 100,
    parameter int ADD_BASE   = 200
) (
    input  logic [UADDR_W-1:0] addr,
    output uword_t             word
);
    function automatic uword_t mk(input logic [SRC_W-1:0] s, input logic [COND_W-1:0] c,
                                  input logic f, input int o, input int n, input int m,
                                  input int r, input int a, input int t);
        uword_t w;
        w.src    = s;
        w.cond   = c;
        w.fin    = f;
        w.outg   = GATE_W'(o);
        w.ing    = GATE_W'(n);
        w.misc   = GATE_W'(m);
        w.rsel   = RSEL_W'(r);
        w.alu    = ALU_W'(a);
        w.target = UADDR_W'(t);
        return w;
    endfunction

    always_comb begin
        case (addr)
            // fetch: address out and increment; Read split off because Cin shares misc
            UADDR_W'(FETCH_BASE):     word = mk(SRC_NEXT, C_NEVER, 1'b0, 0, 0, 5, RSEL_NONE, 3, 0);
            UADDR_W'(FETCH_BASE + 1): word = mk(SRC_NEXT, C_NEVER, 1'b0, 1, 1, 0, RSEL_NONE, ALU_NONE, 0);
            UADDR_W'(FETCH_BASE + 2): word = mk(SRC_LOOKUP, C_ALWAYS, 1'b0, 2, 2, 1, RSEL_NONE, ALU_NONE, 0);
            // add routine
            UADDR_W'(ADD_BASE):       word = mk(SRC_NEXT, C_NEVER, 1'b0, 3, 3, MISC_NONE, 1, ALU_NONE, 0);
            UADDR_W'(ADD_BASE + 1):   word = mk(SRC_NEXT, C_NEVER, 1'b0, 3, IN_NONE, 5, 2, 0, 0);
            UADDR_W'(ADD_BASE + 2):   word = mk(SRC_TARGET, C_ALWAYS, 1'b1, 1, 4, MISC_NONE, 0, ALU_NONE, FETCH_BASE);
            default:                  word = mk(SRC_FETCH, C_ALWAYS, 1'b0, OUT_NONE, IN_NONE, MISC_NONE,
                                                RSEL_NONE, ALU_NONE, 0);
        endcase
    end
endmodule

// File: rtl/vmc_sequencer.sv
module vmc_sequencer
    import vmc_pkg::*;
#(
    parameter int OPC_W      = 5,
    parameter int ADD_OPCODE = 12,
    parameter int FETCH_BASE = 100,
    parameter int ADD_BASE   = 200
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_done,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               cond_con,
    input  logic               cond_zero,
    input  logic [SRC_W-1:0]   src,
    input  logic [COND_W-1:0]  cond,
    input  logic               fin,
    input  logic               is_wait,
    input  logic [UADDR_W-1:0] target,
    output logic [UADDR_W-1:0] upc
);
    typedef struct packed {
        logic [UADDR_W-1:0] upc;
    } seq_t;

    seq_t s_d, s_q;
    logic [UADDR_W-1:0] inc, lookup, chosen;
    logic take, hold;

    always_comb begin
        inc    = s_q.upc + UADDR_W'(1);
        lookup = (opcode == OPC_W'(ADD_OPCODE)) ? UADDR_W'(ADD_BASE) : UADDR_W'(FETCH_BASE);
        case (src)
            SRC_NEXT:   chosen = inc;
            SRC_LOOKUP: chosen = lookup;
            SRC_FETCH:  chosen = UADDR_W'(FETCH_BASE);
            default:    chosen = target;
        endcase
        case (cond)
            C_ALWAYS:  take = 1'b1;
            C_CON:     take = cond_con;
            C_NOTCON:  take = !cond_con;
            C_ZERO:    take = cond_zero;
            C_NONZERO: take = !cond_zero;
            default:   take = 1'b0;
        endcase
        hold = is_wait && !mem_done;
        s_d  = s_q;
        if (!hold) s_d.upc = take ? chosen : inc;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.upc <= UADDR_W'(FETCH_BASE);
        else     s_q <= s_d;
    end

    assign upc = s_q.upc;

    a_r4_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (is_wait && !mem_done) |=> (upc == $past(upc)));

    a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
        (cond == C_NEVER && !is_wait) |=> (upc == $past(upc) + UADDR_W'(1)));

    a_r7_end_returns: assert property (@(posedge clk) disable iff (rst)
        fin |=> (upc == UADDR_W'(FETCH_BASE)));

    a_r5_lookup_add: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_LOOKUP && cond == C_ALWAYS && !hold && opcode == OPC_W'(ADD_OPCODE))
        |=> (upc == UADDR_W'(ADD_BASE)));
endmodule

// File: rtl/vmc_control_unit.sv
module vmc_control_unit
    import vmc_pkg::*;
#(
    parameter int OPC_W      = 5,
    parameter int ADD_OPCODE = 12,
    parameter int FETCH_BASE = 100,
    parameter int ADD_BASE   = 200
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mem_done,
    input  logic [OPC_W-1:0]       opcode,
    input  logic                   cond_con,
    input  logic                   cond_zero,
    output logic [(1<<GATE_W)-1:0] out_strb,
    output logic [(1<<GATE_W)-1:0] in_strb,
    output logic [(1<<GATE_W)-1:0] misc_strb,
    output logic [(1<<RSEL_W)-1:0] rsel_strb,
    output logic [(1<<ALU_W)-1:0]  alu_strb,
    output logic                   end_o
);
    logic [UADDR_W-1:0] upc;
    uword_t             word;

    vmc_store #(.FETCH_BASE(FETCH_BASE), .ADD_BASE(ADD_BASE)) store_i (
        .addr (upc),
        .word (word)
    );

    vmc_sequencer #(
        .OPC_W(OPC_W), .ADD_OPCODE(ADD_OPCODE),
        .FETCH_BASE(FETCH_BASE), .ADD_BASE(ADD_BASE)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .mem_done  (mem_done),
        .opcode    (opcode),
        .cond_con  (cond_con),
        .cond_zero (cond_zero),
        .src       (word.src),
        .cond      (word.cond),
        .fin       (word.fin),
        .is_wait   (word.misc == MISC_WAIT),
        .target    (word.target),
        .upc       (upc)
    );

    vmc_onehot #(.W(GATE_W), .NONE(OUT_NONE)) dec_out_i (.code(word.outg), .strb(out_strb));
    vmc_onehot #(.W(GATE_W), .NONE(IN_NONE), .MAXC(5)) dec_in_i (.code(word.ing), .strb(in_strb));
    vmc_onehot #(.W(GATE_W), .NONE(MISC_NONE)) dec_misc_i (.code(word.misc), .strb(misc_strb));
    vmc_onehot #(.W(RSEL_W), .NONE(RSEL_NONE)) dec_rsel_i (.code(word.rsel), .strb(rsel_strb));
    vmc_onehot #(.W(ALU_W), .NONE(ALU_NONE)) dec_alu_i (.code(word.alu), .strb(alu_strb));

    assign end_o = word.fin;

    a_r2_out_onehot:  assert property (@(posedge clk) disable iff (rst) $onehot0(out_strb));
    a_r2_in_onehot:   assert property (@(posedge clk) disable iff (rst) $onehot0(in_strb));
    a_r2_misc_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(misc_strb));
    a_r2_rsel_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(rsel_strb));
    a_r2_alu_onehot:  assert property (@(posedge clk) disable iff (rst) $onehot0(alu_strb));
    a_r7_end_fetch:   assert property (@(posedge clk) disable iff (rst)
        end_o |=> (in_strb[0] && out_strb[0]));
endmodule

// File: tb/vmc_control_unit_tb_top.sv
module vmc_control_unit_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mem_done = 1'b0;
    logic [4:0] opcode = 5'd12;
    logic cond_con = 1'b0, cond_zero = 1'b0;
    logic [7:0] out_strb, in_strb, misc_strb;
    logic [3:0] rsel_strb;
    logic [15:0] alu_strb;
    logic end_o;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    vmc_control_unit dut_i (
        .clk(clk), .rst(rst), .mem_done(mem_done), .opcode(opcode),
        .cond_con(cond_con), .cond_zero(cond_zero),
        .out_strb(out_strb), .in_strb(in_strb), .misc_strb(misc_strb),
        .rsel_strb(rsel_strb), .alu_strb(alu_strb), .end_o(end_o)
    );

    // step code {out3, in3, misc3, rsel2, alu4, end1}
    localparam logic [15:0] S100 = {3'd0, 3'd0, 3'd5, 2'd3, 4'd3,  1'b0};
    localparam logic [15:0] S101 = {3'd1, 3'd1, 3'd0, 2'd3, 4'd14, 1'b0};
    localparam logic [15:0] S102 = {3'd2, 3'd2, 3'd1, 2'd3, 4'd14, 1'b0};
    localparam logic [15:0] S200 = {3'd3, 3'd3, 3'd7, 2'd1, 4'd14, 1'b0};
    localparam logic [15:0] S201 = {3'd3, 3'd6, 3'd5, 2'd2, 4'd0,  1'b0};
    localparam logic [15:0] S202 = {3'd1, 3'd4, 3'd7, 2'd0, 4'd14, 1'b1};

    // vector {mem_done, opcode, expected step}
    localparam int NV = 15;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 5'd12, S100},   // R1 first cycle after reset
        {1'b0, 5'd12, S101},   // R3
        {1'b0, 5'd12, S102},   // R3 / R4 wait begins
        {1'b0, 5'd12, S102},   // R4 held
        {1'b1, 5'd12, S102},   // R4 done arrives
        {1'b0, 5'd12, S200},   // R5 add lookup, R6
        {1'b0, 5'd12, S201},   // R6
        {1'b0, 5'd12, S202},   // R7
        {1'b0, 5'd12, S100},   // R7 back to fetch
        {1'b0, 5'd12, S101},   // R3
        {1'b1, 5'd7,  S102},   // R5 other opcode
        {1'b0, 5'd12, S100},   // R5 returns to fetch
        {1'b0, 5'd12, S101},   // R3
        {1'b1, 5'd12, S102},   // R4 no stall
        {1'b0, 5'd12, S200}    // R5
    };

    function automatic logic [15:0] oh(input int code, input int none);
        return (code == none) ? 16'd0 : (16'd1 << code);
    endfunction

    task automatic check(input logic [15:0] st, input string tag);
        logic [7:0] eo, ei, em;
        logic [3:0] er;
        logic [15:0] ea;
        eo = 8'(oh(int'(st[15:13]), 7));
        ei = 8'(oh(int'(st[12:10]), 6));
        em = 8'(oh(int'(st[9:7]), 7));
        er = 4'(oh(int'(st[6:5]), 3));
        ea = oh(int'(st[4:1]), 14);
        n_chk++;
        if (out_strb !== eo || in_strb !== ei || misc_strb !== em ||
            rsel_strb !== er || alu_strb !== ea || end_o !== st[0]) begin
            n_bad++;
            $display("FAIL %s: got out=%h in=%h misc=%h rsel=%h alu=%h end=%b exp out=%h in=%h misc=%h rsel=%h alu=%h end=%b",
                     tag, out_strb, in_strb, misc_strb, rsel_strb, alu_strb, end_o,
                     eo, ei, em, er, ea, st[0]);
        end
    endtask

    task automatic step(input logic d, input logic [4:0] op, input logic [15:0] st, input string tag);
        @(negedge clk);
        mem_done = d;
        opcode = op;
        #5;
        check(st, tag);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running exp finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        #5;
        check(S100, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            if (i > 0) @(negedge clk);
            mem_done = VEC[i][21];
            opcode = VEC[i][20:16];
            #5;
            check(VEC[i][15:0], $sformatf("vector %0d", i));
        end
        // now at step 200; advance to 201 then reset mid-routine
        step(1'b0, 5'd12, S201, "R6 before reset");
        @(negedge clk);
        rst = 1'b1;
        #5;
        check(S202, "R8 reset not yet sampled");
        step(1'b0, 5'd12, S100, "R8 reset mid-routine");
        @(negedge clk);
        rst = 1'b0;
        #5;
        check(S100, "R1 after reset release");
        step(1'b0, 5'd12, S101, "R3 fetch second step");
        for (int k = 0; k < 6; k++) step(1'b0, 5'd3, S102, "R4 long stall");
        step(1'b1, 5'd12, S102, "R4 done raised");
        step(1'b0, 5'd12, S200, "R5 add entry after stall");
        step(1'b0, 5'd12, S201, "R6 add step two");
        step(1'b0, 5'd12, S202, "R7 end step");
        step(1'b0, 5'd12, S100, "R7 back to fetch");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule